// File: doc/BRIEF.md
# Burst Serial Register Port

A slave serial port that gives a host access to a 32-entry byte register file. A transaction is framed by an active-low select and clocked by a serial clock. The first byte is an instruction that carries the direction, a burst length of one to four bytes and a starting address. The data bytes follow, most significant bit first, and the address steps down by one after each byte. The serial pins are sampled by a fast system clock, so the whole port lives in one clock domain with a synchronous reset.

Read data can leave on the bidirectional data pin alone (3-wire), or on that pin and on a dedicated output pin together (4-wire). A control bit in the register file picks the mode. Two 13-bit two's-complement offset values sit in a group of four registers. The values a downstream datapath sees are held in a shadow, and the shadow updates all at once, only when the low byte of channel A is written.

Top module: `burst_reg_port`

## Requirements
- R1: Instruction byte: bit 7 = 1 selects a read and 0 a write; bits 6:5 hold the byte count minus one (00 = 1 byte through 11 = 4 bytes); bits 4:0 hold the start address.
- R2: Input bits are taken on rising serial-clock edges, and both instruction and data travel most significant bit first.
- R3: After each complete data byte the address decrements by one and wraps from 0x00 to 0x1F.
- R4: Read bits change only on falling serial-clock edges. The data pin is undriven up to the falling edge that follows the eighth instruction bit, and that edge puts out data bit 7.
- R5: With register 0x00 bit 0 = 0 (3-wire), read data appears on `sdio_o` with `sdio_oe` = 1 and `sdo_oe` stays 0.
- R6: With register 0x00 bit 0 = 1 (4-wire), `sdo_o` carries the same read bits as `sdio_o`. From the falling edge after the last read bit, `sdo_o` drives 0 with `sdo_oe` = 1 until select rises, while `sdio_oe` drops at that same edge.
- R7: `ofs_a` = {reg 0x1D[4:0], reg 0x1C} and `ofs_b` = {reg 0x1F[4:0], reg 0x1E}. Both load together, only when address 0x1C is written. Writes to 0x1D, 0x1E and 0x1F leave both outputs unchanged.
- R8: If select rises before a byte is complete, the partial byte is dropped with no write, and both output enables drop.
- R9: Address 0x05 is read-only and returns `sense_byte`; writes to it are ignored. Addresses 0x18 to 0x1B are not implemented: they read 0 and ignore writes.
- R10: Serial clocks after the burst count is used up write nothing.
- R11: After reset all registers, both offsets and both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock |
| csn | input | 1 | Active-low transaction select |
| sdio_i | input | 1 | Bidirectional data pin, input side |
| sdio_o | output | 1 | Bidirectional data pin, output value |
| sdio_oe | output | 1 | Output enable for the bidirectional data pin |
| sdo_o | output | 1 | Dedicated serial output value |
| sdo_oe | output | 1 | Output enable for the dedicated output (0 = high impedance) |
| sense_byte | input | 8 | Value returned by the read-only register |
| ofs_a | output | 13 | Active channel A offset |
| ofs_b | output | 13 | Active channel B offset |
| reg_bus | output | 256 | Register contents, byte i at bits 8i+7:8i |

## Verification
A wrong internal state becomes visible at the next read of the affected address. A bit counter that slips or an address that steps wrongly corrupts every later byte of the burst, and the bench sees this within one transaction. A shadow that loads on the wrong write shows up on `ofs_a`/`ofs_b` two system clocks after the offending rising serial edge. A pin enable left set after select rises shows up a few system clocks after the select edge.

// File: rtl/brp_pkg.sv
package brp_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int NREG   = 1 << ADDR_W;
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int CNT_W  = 2;
    localparam int OFS_W  = 13;
    localparam int OFS_HI_W = OFS_W - DATA_W;

    localparam logic [ADDR_W-1:0] CTRL_ADDR  = 5'h00;
    localparam logic [ADDR_W-1:0] SENSE_ADDR = 5'h05;
    localparam logic [ADDR_W-1:0] GAP_LO     = 5'h18;
    localparam logic [ADDR_W-1:0] GAP_HI     = 5'h1B;
    localparam logic [ADDR_W-1:0] OFS_A_LO   = 5'h1C;
    localparam logic [ADDR_W-1:0] OFS_A_HI   = 5'h1D;
    localparam logic [ADDR_W-1:0] OFS_B_LO   = 5'h1E;
    localparam logic [ADDR_W-1:0] OFS_B_HI   = 5'h1F;

    typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_DONE} phase_e;

    typedef struct packed {
        logic              rnw;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic sel;
        logic din;
    } pin_ev_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_t;

    function automatic logic is_gap(input logic [ADDR_W-1:0] a);
        return (a >= GAP_LO) && (a <= GAP_HI);
    endfunction

    function automatic logic is_stored(input logic [ADDR_W-1:0] a);
        return (a != SENSE_ADDR) && !is_gap(a);
    endfunction
endpackage

// File: rtl/brp_pins.sv
module brp_pins
    import brp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk,
    input  logic    csn,
    input  logic    sdi,
    output pin_ev_t ev
);
    logic sclk_s, sclk_q, csn_s, sdi_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s <= 1'b0;
            sclk_q <= 1'b0;
            csn_s  <= 1'b1;
            sdi_s  <= 1'b0;
        end else begin
            sclk_s <= sclk;
            sclk_q <= sclk_s;
            csn_s  <= csn;
            sdi_s  <= sdi;
        end
    end

    always_comb begin
        ev.sel  = ~csn_s;
        ev.rise = sclk_s & ~sclk_q & ~csn_s;
        ev.fall = ~sclk_s & sclk_q & ~csn_s;
        ev.din  = sdi_s;
    end
endmodule

// File: rtl/brp_frame.sv
module brp_frame
    import brp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev,
    input  logic              four_wire,
    input  logic [DATA_W-1:0] rd_byte,
    output wr_t               wr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              dout,
    output logic              drv_en,
    output logic              tail_low
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    phase_e            phase;
    logic [BIT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  byte_cnt;
    instr_t            ins;
    logic [DATA_W-2:0] shin;
    logic [DATA_W-1:0] shout;
    logic [DATA_W-1:0] full_byte;
    logic              byte_step;

    assign full_byte = {shin, ev.din};
    assign byte_step = ev.rise && (phase == PH_DATA) && (bit_cnt == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_CMD;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            ins      <= '0;
            shin     <= '0;
            shout    <= '0;
            drv_en   <= 1'b0;
            tail_low <= 1'b0;
        end else if (!ev.sel) begin
            phase    <= PH_CMD;
            bit_cnt  <= '0;
            drv_en   <= 1'b0;
            tail_low <= 1'b0;
        end else begin
            if (ev.rise) begin
                unique case (phase)
                    PH_CMD: begin
                        shin    <= {shin[DATA_W-3:0], ev.din};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) begin
                            ins      <= instr_t'(full_byte);
                            byte_cnt <= '0;
                            phase    <= PH_DATA;
                        end
                    end
                    PH_DATA: begin
                        shin    <= {shin[DATA_W-3:0], ev.din};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) begin
                            ins.addr <= ins.addr - 1'b1;
                            byte_cnt <= byte_cnt + 1'b1;
                            if (byte_cnt == ins.cnt)
                                phase <= PH_DONE;
                        end
                    end
                    default: ;
                endcase
            end
            if (ev.fall) begin
                unique case (phase)
                    PH_DATA: begin
                        if (ins.rnw) begin
                            if (bit_cnt == '0) begin
                                shout  <= rd_byte;
                                drv_en <= 1'b1;
                            end else begin
                                shout <= {shout[DATA_W-2:0], 1'b0};
                            end
                        end
                    end
                    PH_DONE: begin
                        if (drv_en) begin
                            drv_en   <= 1'b0;
                            tail_low <= four_wire;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        wr.en   = byte_step && !ins.rnw;
        wr.addr = ins.addr;
        wr.data = full_byte;
    end

    assign rd_addr = ins.addr;
    assign dout    = shout[DATA_W-1];

    // R4: the read shift register moves only after a falling edge
    a_r4_shift_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(shout) |-> $past(ev.fall));

    // R3: one decrement per finished byte, wrapping below zero
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        byte_step |=> (ins.addr == $past(ins.addr) - 1'b1));

    // R8: a released select frees both pins
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        !ev.sel |=> (!drv_en && !tail_low));

    // R5: the data pin is only driven for read bursts
    a_r5_drive_read: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> ins.rnw);

    // R6: the low tail appears only in 4-wire mode
    a_r6_tail_4wire: assert property (@(posedge clk) disable iff (rst)
        tail_low |-> four_wire);
endmodule

// File: rtl/brp_regfile.sv
module brp_regfile
    import brp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  wr_t                    wr,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [DATA_W-1:0]      sense_byte,
    output logic [DATA_W-1:0]      rd_byte,
    output logic                   four_wire,
    output logic [OFS_W-1:0]       ofs_a,
    output logic [OFS_W-1:0]       ofs_b,
    output logic [NREG*DATA_W-1:0] reg_bus
);
    logic [DATA_W-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
            ofs_a <= '0;
            ofs_b <= '0;
        end else if (wr.en) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr.addr == ADDR_W'(i) && is_stored(ADDR_W'(i)))
                    mem[i] <= wr.data;
            end
            if (wr.addr == OFS_A_LO) begin
                ofs_a <= {mem[OFS_A_HI][OFS_HI_W-1:0], wr.data};
                ofs_b <= {mem[OFS_B_HI][OFS_HI_W-1:0], mem[OFS_B_LO]};
            end
        end
    end

    always_comb begin
        if (rd_addr == SENSE_ADDR)
            rd_byte = sense_byte;
        else if (is_gap(rd_addr))
            rd_byte = '0;
        else
            rd_byte = mem[rd_addr];
    end

    assign four_wire = mem[CTRL_ADDR][0];

    for (genvar g = 0; g < NREG; g++) begin : g_bus
        assign reg_bus[g*DATA_W +: DATA_W] = mem[g];
    end

    // R7: the active offsets move only after a write to the trigger address
    a_r7_shadow_trigger: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ofs_a) || !$stable(ofs_b)) |-> $past(wr.en && wr.addr == OFS_A_LO));
endmodule

// File: rtl/burst_reg_port.sv
module burst_reg_port
    import brp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sclk,
    input  logic                   csn,
    input  logic                   sdio_i,
    output logic                   sdio_o,
    output logic                   sdio_oe,
    output logic                   sdo_o,
    output logic                   sdo_oe,
    input  logic [7:0]             sense_byte,
    output logic [12:0]            ofs_a,
    output logic [12:0]            ofs_b,
    output logic [255:0]           reg_bus
);
    pin_ev_t           ev;
    wr_t               wr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_byte;
    logic              four_wire, dout, drv_en, tail_low;

    brp_pins u_pins (
        .clk(clk), .rst(rst), .sclk(sclk), .csn(csn), .sdi(sdio_i), .ev(ev)
    );

    brp_frame u_frame (
        .clk(clk), .rst(rst), .ev(ev), .four_wire(four_wire),
        .rd_byte(rd_byte), .wr(wr), .rd_addr(rd_addr), .dout(dout),
        .drv_en(drv_en), .tail_low(tail_low)
    );

    brp_regfile u_regs (
        .clk(clk), .rst(rst), .wr(wr), .rd_addr(rd_addr),
        .sense_byte(sense_byte), .rd_byte(rd_byte), .four_wire(four_wire),
        .ofs_a(ofs_a), .ofs_b(ofs_b), .reg_bus(reg_bus)
    );

    assign sdio_o  = dout;
    assign sdio_oe = drv_en;
    assign sdo_o   = tail_low ? 1'b0 : dout;
    assign sdo_oe  = tail_low | (drv_en & four_wire);
endmodule

// File: tb/sim_burst_reg_port.sv
module sim_burst_reg_port;
    logic clk = 1'b0, rst = 1'b1;
    logic sclk = 1'b0, csn = 1'b1, sdio_i = 1'b0;
    logic [7:0] sense_byte = 8'h00;
    logic sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [12:0] ofs_a, ofs_b;
    logic [255:0] reg_bus;

    int errors = 0, checks = 0;
    bit done = 0;

    // per-transfer observations
    logic [31:0] rd;
    int   mism4, drive3;
    logic pre_oe, tail_sdo_oe, tail_sdo, tail_sdio_oe, end_sdo_oe, end_sdio_oe;

    always #5 clk = ~clk;

    burst_reg_port u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .csn(csn), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
        .sense_byte(sense_byte), .ofs_a(ofs_a), .ofs_b(ofs_b), .reg_bus(reg_bus)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hc();
        repeat (5) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sdio_i = b;
        hc();
        sclk = 1'b1;
        hc();
        sclk = 1'b0;
    endtask

    task automatic xfer(input logic rnw, input int n, input logic [4:0] a,
                        input logic [31:0] wd, input int nbits, input bit w4);
        logic [7:0] ins;
        ins = {rnw, 2'(n - 1), a};
        rd = '0; mism4 = 0; drive3 = 0;
        csn = 1'b0;
        hc();
        for (int i = 0; i < 8; i++) begin
            sdio_i = ins[7 - i];
            hc();
            sclk = 1'b1;
            hc();
            if (i == 7) pre_oe = sdio_oe;
            sclk = 1'b0;
        end
        for (int j = 0; j < nbits; j++) begin
            sdio_i = wd[nbits - 1 - j];
            hc();
            if (rnw) begin
                rd = {rd[30:0], sdio_o};
                if (w4 && (sdo_o !== sdio_o || sdo_oe !== 1'b1)) mism4++;
            end
            if (!w4 && sdo_oe) drive3++;
            sclk = 1'b1;
            hc();
            sclk = 1'b0;
        end
        hc();
        tail_sdo_oe = sdo_oe; tail_sdo = sdo_o; tail_sdio_oe = sdio_oe;
        csn = 1'b1;
        hc();
        end_sdo_oe = sdo_oe; end_sdio_oe = sdio_oe;
        hc();
    endtask

    task automatic wr_b(input int n, input logic [4:0] a, input logic [31:0] d);
        xfer(1'b0, n, a, d, n * 8, 1'b0);
    endtask

    task automatic rd_b(input int n, input logic [4:0] a, input bit w4);
        xfer(1'b1, n, a, 32'h0, n * 8, w4);
    endtask

    // {rnw, count-1, addr, data}
    localparam logic [39:0] VEC [8] = '{
        {1'b0, 2'd3, 5'h0A, 32'h11223344},
        {1'b0, 2'd0, 5'h12, 32'h000000A5},
        {1'b1, 2'd3, 5'h0A, 32'h11223344},
        {1'b1, 2'd1, 5'h13, 32'h000000A5},
        {1'b0, 2'd2, 5'h17, 32'h00C33C5A},
        {1'b1, 2'd2, 5'h17, 32'h00C33C5A},
        {1'b1, 2'd0, 5'h08, 32'h00000033},
        {1'b1, 2'd1, 5'h09, 32'h00002233}
    };

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R11 reset state
        check(sdio_oe == 0 && sdo_oe == 0, "R11 enables", {sdio_oe, sdo_oe}, 0);
        check(ofs_a == 0 && ofs_b == 0, "R11 offsets", {ofs_a, ofs_b}, 0);
        check(reg_bus == '0, "R11 registers", reg_bus[31:0], 0);

        // R1 R2 R3 table of bursts
        for (int k = 0; k < 8; k++) begin
            logic        v_rnw;
            logic [1:0]  v_cnt;
            logic [4:0]  v_addr;
            logic [31:0] v_dat;
            {v_rnw, v_cnt, v_addr, v_dat} = VEC[k];
            xfer(v_rnw, int'(v_cnt) + 1, v_addr, v_dat, (int'(v_cnt) + 1) * 8, 1'b0);
            if (v_rnw)
                check(rd == v_dat, $sformatf("R1 R2 R3 vector %0d", k), rd, v_dat);
        end

        // R7 shadow group
        wr_b(1, 5'h1F, 32'h0F);
        wr_b(1, 5'h1E, 32'h34);
        wr_b(1, 5'h1D, 32'h12);
        check(ofs_a == 0 && ofs_b == 0, "R7 no load on other three", {ofs_a, ofs_b}, 0);
        wr_b(1, 5'h1C, 32'hAB);
        check(ofs_a == 13'h12AB, "R7 ofs_a load", ofs_a, 32'h12AB);
        check(ofs_b == 13'h0F34, "R7 ofs_b load", ofs_b, 32'h0F34);
        wr_b(4, 5'h1F, 32'h01FF1F00);
        check(ofs_a == 13'h1F00 && ofs_b == 13'h01FF, "R7 burst load",
              {ofs_a, ofs_b}, {13'h1F00, 13'h01FF});

        // R9 read-only and unimplemented
        sense_byte = 8'h9C;
        rd_b(1, 5'h05, 1'b0);
        check(rd == 32'h9C, "R9 sense read", rd, 32'h9C);
        wr_b(1, 5'h05, 32'h11);
        rd_b(1, 5'h05, 1'b0);
        check(rd == 32'h9C && reg_bus[47:40] == 0, "R9 sense write ignored", rd, 32'h9C);
        wr_b(1, 5'h19, 32'h77);
        rd_b(1, 5'h19, 1'b0);
        check(rd == 32'h0, "R9 gap reads zero", rd, 0);

        // R8 abort mid-byte
        wr_b(1, 5'h04, 32'h66);
        xfer(1'b0, 1, 5'h04, 32'h1F, 5, 1'b0);
        check(end_sdio_oe == 0 && end_sdo_oe == 0, "R8 pins released", {end_sdio_oe, end_sdo_oe}, 0);
        rd_b(1, 5'h04, 1'b0);
        check(rd == 32'h66, "R8 partial byte dropped", rd, 32'h66);

        // R10 clocks after the burst
        xfer(1'b0, 1, 5'h03, 32'h81EE, 16, 1'b0);
        rd_b(2, 5'h03, 1'b0);
        check(rd == 32'h8100, "R10 extra bits ignored", rd, 32'h8100);

        // R3 wrap below zero
        wr_b(2, 5'h00, 32'h005E);
        rd_b(1, 5'h1F, 1'b0);
        check(rd == 32'h5E, "R3 wrap write", rd, 32'h5E);
        rd_b(3, 5'h01, 1'b0);
        check(rd == 32'h00005E, "R3 wrap read", rd, 32'h5E);
        check(ofs_a == 13'h1F00, "R7 no load without trigger", ofs_a, 32'h1F00);

        // R4 R5 3-wire read
        rd_b(1, 5'h0A, 1'b0);
        check(pre_oe == 0, "R4 undriven before first fall", pre_oe, 0);
        check(rd == 32'h11, "R5 3-wire data", rd, 32'h11);
        check(drive3 == 0 && tail_sdo_oe == 0, "R5 sdo stays off", drive3, 0);
        check(tail_sdio_oe == 0, "R5 sdio released after burst", tail_sdio_oe, 0);

        // R6 4-wire read
        wr_b(1, 5'h00, 32'h01);
        rd_b(4, 5'h0A, 1'b1);
        check(rd == 32'h11223344, "R6 4-wire data", rd, 32'h11223344);
        check(mism4 == 0, "R6 both pins match", mism4, 0);
        check(tail_sdo_oe == 1 && tail_sdo == 0, "R6 low tail", {tail_sdo_oe, tail_sdo}, 2);
        check(tail_sdio_oe == 0, "R6 sdio released", tail_sdio_oe, 0);
        check(end_sdo_oe == 0, "R6 sdo off after select", end_sdo_oe, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule